// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of wide internal registers through a small window of directly addressed 16-bit registers. The window holds a control/status register, a command (address) register and four 16-bit staging registers. The command word names the target register by functional-block type, instance and parameter. It also gives the direction and the index of the 16-bit word to return on a read.

The host loads the staging registers first, then writes the command register. That write alone launches a transaction of fixed length, and a busy flag in the status register covers it. A write transaction stores the four staged words as one 64-bit value. A read transaction copies the chosen 16-bit word of the target into staging register 0 when it completes. The internal targets are a generic register file. Types and instances outside the map complete normally: their writes are dropped and their reads return zero.

Top module: `ixb_bridge`

## Requirements
- R1: After reset the busy flag, both reset outputs, all staging registers and the command register read 0, and every internal target holds 0.
- R2: Window offset 0 is the status register. Bit 0 reads the busy flag and ignores host writes. Bit 3 drives `glb_rst_n` and bit 4 drives `codec_rst_n`. Both are host-writable and read back. Other bits read 0.
- R3: Writes to the staging registers (window offsets 4..7 for words 0..3) never start a transaction.
- R4: A host write to the command register (window offset 1) while idle starts a transaction. `busy` is high for exactly BUSY_CYC cycles, starting in the cycle after the write.
- R5: Command fields are: bits 15:12 type (1 DMA port with instances 1..6, 9 global DMA control with instance 1, 2 clock generator with instances 1..3, 3 timer with instance 1), bits 11:8 instance, bit 7 direction (1 read, 0 write), bits 3:2 parameter and bits 1:0 word index.
- R6: A write transaction stores {word3, word2, word1, word0} from the staging registers into the addressed target. A later read with word index k returns bits 16k+15:16k of it in staging register 0.
- R7: Targets that differ only in type, instance or parameter are independent storage.
- R8: A command-register write that arrives while busy is ignored. The command register keeps its value, the transaction keeps its timing, and the dropped command has no effect.
- R9: A write transaction uses the staging contents as they were when the command was accepted. Staging writes made while busy do not change the stored value.
- R10: An unmapped type or instance completes in the same BUSY_CYC cycles. Its write changes no target, and its read loads 0 into staging register 0.
- R11: When a read completes in the same cycle as a host write to staging register 0, the readback value is kept and the host write is lost.
- R12: The command register (window offset 1) reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hwr_en | input | 1 | Host write strobe, one write per cycle |
| hwr_addr | input | 3 | Host write window offset |
| hwr_data | input | 16 | Host write data |
| hrd_addr | input | 3 | Host read window offset |
| hrd_data | output | 16 | Host read data, combinational from hrd_addr |
| busy | output | 1 | Transaction in progress |
| glb_rst_n | output | 1 | Global reset, active low, from status bit 3 |
| codec_rst_n | output | 1 | Codec reset, active low, from status bit 4 |

## Verification
Two things can land in the same cycle: a read transaction's completion loading staging register 0, and a host write to that same register. The bench issues a read command and counts BUSY_CYC edges. It then places a host write to staging word 0 exactly on the completion edge. It passes when staging word 0 holds the target's word and not the host's value. A second overlap, a command write during busy, is judged by the unchanged command readback, the unchanged busy length and the untouched target.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    localparam int WORD_W  = 16;
    localparam int NWORD   = 4;
    localparam int STAGE_W = WORD_W * NWORD;
    localparam int WIN_AW  = 3;
    localparam int NGROUP  = 11;
    localparam int NPARAM  = 4;
    localparam int NSLOT   = NGROUP * NPARAM;
    localparam int SLOT_W  = $clog2(NSLOT);

    localparam logic [WIN_AW-1:0] WIN_STAT = 3'd0;
    localparam logic [WIN_AW-1:0] WIN_CMD  = 3'd1;

    localparam int ST_BUSY = 0;
    localparam int ST_GRST = 3;
    localparam int ST_CRST = 4;

    typedef enum logic [3:0] {
        BLK_DMAPORT = 4'd1,
        BLK_CLKGEN  = 4'd2,
        BLK_TIMER   = 4'd3,
        BLK_DMAGLB  = 4'd9
    } ixb_blk_e;

    typedef struct packed {
        logic [3:0] blk;
        logic [3:0] inst;
        logic       rd;
        logic [2:0] spare;
        logic [1:0] param;
        logic [1:0] widx;
    } ixb_cmd_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } ixb_map_t;

    function automatic logic is_stage(logic [WIN_AW-1:0] a);
        return a[WIN_AW-1];
    endfunction

    function automatic ixb_map_t map_cmd(ixb_cmd_t c);
        ixb_map_t m;
        int       grp;
        grp = -1;
        case (c.blk)
            BLK_DMAPORT: if (c.inst >= 4'd1 && c.inst <= 4'd6) grp = int'(c.inst) - 1;
            BLK_DMAGLB:  if (c.inst == 4'd1) grp = 6;
            BLK_CLKGEN:  if (c.inst >= 4'd1 && c.inst <= 4'd3) grp = 6 + int'(c.inst);
            BLK_TIMER:   if (c.inst == 4'd1) grp = 10;
            default:     grp = -1;
        endcase
        m.hit  = (grp >= 0);
        m.slot = m.hit ? SLOT_W'(grp * NPARAM + int'(c.param)) : '0;
        return m;
    endfunction

endpackage

// File: rtl/ixb_regfile.sv
module ixb_regfile
    import ixb_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [REG_W-1:0]  rd_data
);
    logic [REG_W-1:0] mem [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_slot] <= wr_data;
        end
    end

    assign rd_data = mem[rd_slot];
endmodule

// File: rtl/ixb_seq.sv
module ixb_seq
    import ixb_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  ixb_cmd_t           cmd_in,
    input  logic [STAGE_W-1:0] stage_in,
    output logic               busy,
    output logic               done,
    output ixb_cmd_t           cmd_q,
    output logic [STAGE_W-1:0] stage_q
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cmd_q   <= '0;
            stage_q <= '0;
        end else if (start && !busy) begin
            cnt     <= CW'(BUSY_CYC);
            cmd_q   <= cmd_in;
            stage_q <= stage_in;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/ixb_window.sv
module ixb_window
    import ixb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hwr_en,
    input  logic [WIN_AW-1:0]  hwr_addr,
    input  logic [WORD_W-1:0]  hwr_data,
    input  logic [WIN_AW-1:0]  hrd_addr,
    output logic [WORD_W-1:0]  hrd_data,
    input  logic               busy,
    input  logic               rb_load,
    input  logic [WORD_W-1:0]  rb_word,
    output logic               start,
    output ixb_cmd_t           cmd_out,
    output logic [STAGE_W-1:0] stage_out,
    output logic               grst_n,
    output logic               crst_n
);
    logic [WORD_W-1:0] stage [NWORD];
    ixb_cmd_t          cmd_r;

    assign start = hwr_en && (hwr_addr == WIN_CMD) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            grst_n <= 1'b0;
            crst_n <= 1'b0;
            cmd_r  <= '0;
            for (int i = 0; i < NWORD; i++) stage[i] <= '0;
        end else begin
            if (hwr_en && hwr_addr == WIN_STAT) begin
                grst_n <= hwr_data[ST_GRST];
                crst_n <= hwr_data[ST_CRST];
            end
            if (start) cmd_r <= ixb_cmd_t'(hwr_data);
            for (int i = 0; i < NWORD; i++) begin
                if (i == 0 && rb_load) begin
                    stage[i] <= rb_word;
                end else if (hwr_en && is_stage(hwr_addr) && int'(hwr_addr[1:0]) == i) begin
                    stage[i] <= hwr_data;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NWORD; g++) begin : g_stage
            assign stage_out[g*WORD_W +: WORD_W] = stage[g];
        end
    endgenerate

    assign cmd_out = ixb_cmd_t'(hwr_data);

    always_comb begin
        hrd_data = '0;
        if (is_stage(hrd_addr)) begin
            hrd_data = stage[hrd_addr[1:0]];
        end else if (hrd_addr == WIN_CMD) begin
            hrd_data = cmd_r;
        end else if (hrd_addr == WIN_STAT) begin
            hrd_data[ST_BUSY] = busy;
            hrd_data[ST_GRST] = grst_n;
            hrd_data[ST_CRST] = crst_n;
        end
    end
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
    import ixb_pkg::*;
#(
    parameter int BUSY_CYC = 4,
    parameter int REG_W    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hwr_en,
    input  logic [2:0]        hwr_addr,
    input  logic [15:0]       hwr_data,
    input  logic [2:0]        hrd_addr,
    output logic [15:0]       hrd_data,
    output logic              busy,
    output logic              glb_rst_n,
    output logic              codec_rst_n
);
    logic               start;
    logic               done;
    ixb_cmd_t           cmd_new;
    ixb_cmd_t           cmd_q;
    logic [STAGE_W-1:0] stage_new;
    logic [STAGE_W-1:0] stage_q;
    ixb_map_t           tgt;
    logic [REG_W-1:0]   rf_rdata;
    logic [STAGE_W-1:0] rf_ext;
    logic               rb_load;
    logic [WORD_W-1:0]  rb_word;
    logic               rf_we;

    ixb_window i_win (
        .clk       (clk),
        .rst       (rst),
        .hwr_en    (hwr_en),
        .hwr_addr  (hwr_addr),
        .hwr_data  (hwr_data),
        .hrd_addr  (hrd_addr),
        .hrd_data  (hrd_data),
        .busy      (busy),
        .rb_load   (rb_load),
        .rb_word   (rb_word),
        .start     (start),
        .cmd_out   (cmd_new),
        .stage_out (stage_new),
        .grst_n    (glb_rst_n),
        .crst_n    (codec_rst_n)
    );

    ixb_seq #(.BUSY_CYC(BUSY_CYC)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_in   (cmd_new),
        .stage_in (stage_new),
        .busy     (busy),
        .done     (done),
        .cmd_q    (cmd_q),
        .stage_q  (stage_q)
    );

    assign tgt   = map_cmd(cmd_q);
    assign rf_we = done && !cmd_q.rd && tgt.hit;

    ixb_regfile #(.REG_W(REG_W)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_we),
        .wr_slot (tgt.slot),
        .wr_data (REG_W'(stage_q)),
        .rd_slot (tgt.slot),
        .rd_data (rf_rdata)
    );

    assign rf_ext  = STAGE_W'(rf_rdata);
    assign rb_load = done && cmd_q.rd;
    assign rb_word = tgt.hit ? rf_ext[cmd_q.widx*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/ixb_checker.sv
module ixb_checker #(
    parameter int BUSY_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       hwr_en,
    input logic [2:0] hwr_addr,
    input logic       busy,
    input logic       done,
    input logic       glb_rst_n,
    input logic       codec_rst_n
);
    localparam int LW = $clog2(BUSY_CYC + 2);
    logic [LW-1:0] blen;

    always_ff @(posedge clk) begin
        if (rst)       blen <= '0;
        else if (busy) blen <= blen + 1'b1;
        else           blen <= '0;
    end

    // R4: an accepted command raises busy on the next cycle
    a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
        (hwr_en && hwr_addr == 3'd1 && !busy) |=> busy);

    // R3: staging writes while idle leave the block idle
    a_r3_stage_no_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && hwr_en && hwr_addr[2]) |=> !busy);

    // R4: completion ends the busy window
    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R8: no busy window outlasts BUSY_CYC, so no restart while busy
    a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
        blen <= LW'(BUSY_CYC));

    // R2: reset outputs move only on a status write
    a_r2_rst_hold: assert property (@(posedge clk) disable iff (rst)
        !(hwr_en && hwr_addr == 3'd0) |=> ($stable(glb_rst_n) && $stable(codec_rst_n)));
endmodule

bind ixb_bridge ixb_checker #(.BUSY_CYC(BUSY_CYC)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .hwr_en      (hwr_en),
    .hwr_addr    (hwr_addr),
    .busy        (busy),
    .done        (done),
    .glb_rst_n   (glb_rst_n),
    .codec_rst_n (codec_rst_n)
);

// File: tb/test_ixb_bridge.sv
`timescale 1ns/1ps
module test_ixb_bridge;
    localparam int BUSY_CYC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hwr_en = 1'b0;
    logic [2:0]  hwr_addr = '0;
    logic [15:0] hwr_data = '0;
    logic [2:0]  hrd_addr = '0;
    logic [15:0] hrd_data;
    logic        busy;
    logic        glb_rst_n;
    logic        codec_rst_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ixb_bridge #(.BUSY_CYC(BUSY_CYC)) i_ixb_bridge (
        .clk(clk), .rst(rst), .hwr_en(hwr_en), .hwr_addr(hwr_addr),
        .hwr_data(hwr_data), .hrd_addr(hrd_addr), .hrd_data(hrd_data),
        .busy(busy), .glb_rst_n(glb_rst_n), .codec_rst_n(codec_rst_n)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(int blk, int inst, bit rd, int prm, int idx);
        return {4'(blk), 4'(inst), rd, 3'b000, 2'(prm), 2'(idx)};
    endfunction

    // called at a negedge; write lands on the next posedge; returns at negedge
    task automatic wr(logic [2:0] a, logic [15:0] d);
        hwr_en = 1'b1; hwr_addr = a; hwr_data = d;
        @(negedge clk);
        hwr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        hrd_addr = a;
        #0.5;
        d = hrd_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic stage(logic [63:0] v);
        for (int i = 0; i < 4; i++) wr(3'(4 + i), v[i*16 +: 16]);
    endtask

    task automatic put(int blk, int inst, int prm, logic [63:0] v);
        stage(v);
        wr(3'd1, mk(blk, inst, 1'b0, prm, 0));
        wait_idle();
    endtask

    task automatic get(int blk, int inst, int prm, output logic [63:0] v);
        logic [15:0] w;
        for (int i = 0; i < 4; i++) begin
            wr(3'd1, mk(blk, inst, 1'b1, prm, i));
            wait_idle();
            rd(3'd4, w);
            v[i*16 +: 16] = w;
        end
    endtask

    task automatic t_reset();
        logic [15:0] w;
        logic [63:0] v;
        rd(3'd0, w); check("R1 status", w, 0);
        check("R1 pins", {glb_rst_n, codec_rst_n, busy}, 0);
        rd(3'd1, w); check("R1 cmd", w, 0);
        for (int i = 0; i < 4; i++) begin
            rd(3'(4 + i), w); check("R1 stage", w, 0);
        end
        get(9, 1, 2, v); check("R1 target", v, 0);
    endtask

    task automatic t_status();
        logic [15:0] w;
        wr(3'd0, 16'hFFFF);
        rd(3'd0, w); check("R2 status rw", w, 16'h0018);
        check("R2 pins high", {glb_rst_n, codec_rst_n, busy}, 3'b110);
        wr(3'd0, 16'h0008);
        check("R2 pins mix", {glb_rst_n, codec_rst_n}, 2'b10);
        wr(3'd0, 16'h0018);
    endtask

    task automatic t_stage_only();
        bit seen = 0;
        stage(64'h1111_2222_3333_4444);
        for (int i = 0; i < 3; i++) begin
            if (busy) seen = 1;
            @(negedge clk);
        end
        check("R3 no start", seen, 0);
    endtask

    task automatic t_busy_len();
        int n = 0;
        logic [15:0] w;
        wr(3'd1, mk(1, 2, 1'b0, 0, 0));
        while (busy) begin n++; @(negedge clk); end
        check("R4 busy len", n, BUSY_CYC);
        rd(3'd0, w); check("R4 status idle", w[0], 0);
    endtask

    task automatic t_wide();
        logic [63:0] v;
        put(2, 3, 1, 64'hDEAD_BEEF_0123_4567);
        get(2, 3, 1, v); check("R6 R5 wide readback", v, 64'hDEAD_BEEF_0123_4567);
        put(3, 1, 3, 64'hA5A5_0F0F_5A5A_F0F0);
        get(3, 1, 3, v); check("R6 timer", v, 64'hA5A5_0F0F_5A5A_F0F0);
    endtask

    task automatic t_indep();
        logic [63:0] v;
        put(1, 4, 2, 64'h0000_0000_0000_AAAA);
        put(1, 5, 2, 64'h0000_0000_0000_BBBB);
        put(1, 4, 1, 64'h0000_0000_0000_CCCC);
        put(9, 1, 2, 64'h0000_0000_0000_DDDD);
        get(1, 4, 2, v); check("R7 inst4 prm2", v, 64'hAAAA);
        get(1, 5, 2, v); check("R7 inst5", v, 64'hBBBB);
        get(1, 4, 1, v); check("R7 prm1", v, 64'hCCCC);
        get(9, 1, 2, v); check("R7 glb type", v, 64'hDDDD);
    endtask

    task automatic t_ignore_busy();
        int n = 1;
        logic [15:0] w;
        logic [63:0] v;
        stage(64'h0000_0000_0000_1234);
        wr(3'd1, mk(2, 1, 1'b0, 0, 0));
        wr(3'd1, mk(2, 2, 1'b0, 0, 0));
        while (busy) begin n++; @(negedge clk); end
        check("R8 busy unchanged", n, BUSY_CYC);
        rd(3'd1, w); check("R8 R12 cmd kept", w, mk(2, 1, 1'b0, 0, 0));
        get(2, 2, 0, v); check("R8 dropped cmd no effect", v, 0);
        get(2, 1, 0, v); check("R8 first cmd done", v, 64'h1234);
    endtask

    task automatic t_snapshot();
        logic [63:0] v;
        stage(64'h0004_0003_0002_0001);
        wr(3'd1, mk(1, 6, 1'b0, 3, 0));
        stage(64'hFFFF_FFFF_FFFF_FFFF);
        wait_idle();
        get(1, 6, 3, v); check("R9 snapshot", v, 64'h0004_0003_0002_0001);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        logic [15:0] w;
        put(1, 1, 0, 64'h0000_0000_0000_7777);
        stage(64'h9999_9999_9999_9999);
        wr(3'd1, mk(5, 1, 1'b0, 0, 0));
        wait_idle();
        wr(3'd1, mk(1, 7, 1'b0, 0, 0));
        wait_idle();
        wr(3'd1, mk(5, 1, 1'b1, 0, 0));
        wait_idle();
        rd(3'd4, w); check("R10 unmapped type read", w, 0);
        wr(3'd4, 16'h5555);
        wr(3'd1, mk(1, 7, 1'b1, 0, 0));
        wait_idle();
        rd(3'd4, w); check("R10 unmapped inst read", w, 0);
        get(1, 1, 0, v); check("R10 mapped untouched", v, 64'h7777);
    endtask

    task automatic t_collision();
        logic [15:0] w;
        put(3, 1, 0, 64'h0000_0000_0000_4242);
        wr(3'd1, mk(3, 1, 1'b1, 0, 0));
        repeat (BUSY_CYC - 1) @(negedge clk);
        wr(3'd4, 16'hBAD0);
        check("R11 idle after", busy, 0);
        rd(3'd4, w); check("R11 readback wins", w, 16'h4242);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status();
        t_stage_only();
        t_busy_len();
        t_wide();
        t_indep();
        t_ignore_busy();
        t_snapshot();
        t_unmapped();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule